// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller

This block sequences one acquisition into a circular sample memory of `2**ADDR_W` words. Once started it writes every valid sample at an incrementing address that wraps around the ring, while it waits for a trigger. The first trigger opens a post-trigger phase that lasts for a fixed number of samples. That number comes from a percentage setting. When the phase completes, the block goes back to idle and reports where the trigger fell in the ring.

Three inputs start and end a capture: a host start request, a trigger pulse from an external detector, and a single push button. The button cycles through the phases. In idle it starts a capture. While the block waits for a trigger it forces one. After the trigger it stops the capture early.

The pre-trigger region is the memory that the post-trigger share leaves over. If the trigger comes early, the unfilled part of that region stays empty. If the trigger comes late, the oldest pre-trigger samples are given up. A latched "wrapped" flag records which of the two cases happened. Readout logic uses the flag and the trigger address to rebuild the order of the record: if the flag is clear the record starts at address 0, and if it is set the record starts at the trigger address minus the pre-trigger size.

Top module: `cap_ctrl`

## Requirements
- R1: After reset, `st_idle` is 1, `st_armed`, `st_trig`, `done`, `trig_pulse` and `wrapped` are 0, `trig_addr` is 0, and `wr_en` stays 0 even when `sample_vld` is high.
- R2: A `start_req` pulse or a button press in idle moves the block to the armed state (`st_armed`=1). Valid samples in the armed and triggered states are written at addresses 0, 1, 2, and so on, modulo `2**ADDR_W`.
- R3: A button press in the armed state acts as a trigger: the block moves to the triggered state (`st_trig`=1) and `trig_pulse` fires.
- R4: A button press in the triggered state ends the capture at once. `done` pulses, the block returns to idle, and no later valid sample is written.
- R5: The post-trigger count is floor(2**ADDR_W × p / 100), raised to 1 if it is 0, where p is `post_pct` clamped to the range 1..99. The count is taken at start. The capture ends after exactly that many valid samples, counting the sample in the trigger cycle as the first.
- R6: If the trigger comes after no more than (2**ADDR_W − post count) pre-trigger samples, `wrapped` reads 0. The post-trigger phase still ends after its own count.
- R7: If more pre-trigger samples are written than the pre-trigger region holds, `wrapped` reads 1 after completion.
- R8: A `trig_in` pulse in the triggered state does not change when the capture ends.
- R9: `trig_pulse` is a one-cycle pulse in the cycle after the first trigger. When `pulse_every`=1 it also pulses in the cycle after each `trig_in` seen in the triggered state.
- R10: `done` is a one-cycle pulse in the cycle after the capture ends. In that same cycle `trig_addr` takes the ring address of the first post-trigger sample slot, and `wrapped` takes the overrun flag.
- R11: A button held high for many cycles makes exactly one state transition. The button passes through a two-flop synchronizer and a rising-edge detector.
- R12: `trig_in` in idle and `start_req` outside idle have no effect. The state and the write address sequence carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Host start request, one-cycle pulse |
| trig_in | input | 1 | Trigger pulse from the detector |
| btn_in | input | 1 | Asynchronous push button, active high |
| sample_vld | input | 1 | A sample is present this cycle |
| post_pct | input | PCT_W | Post-trigger share in percent (clamped to 1..99) |
| pulse_every | input | 1 | 1: pulse on every trigger; 0: first trigger only |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Memory write address |
| st_idle | output | 1 | No capture in progress |
| st_armed | output | 1 | Capturing, waiting for trigger |
| st_trig | output | 1 | Capturing after trigger |
| trig_pulse | output | 1 | Trigger indication pulse |
| done | output | 1 | Capture finished, one-cycle pulse |
| trig_addr | output | ADDR_W | Address of first post-trigger slot, latched at completion |
| wrapped | output | 1 | Oldest pre-trigger samples were dropped, latched at completion |

## Verification
The assertions assume that `trig_in`, `start_req` and `sample_vld` are clean synchronous levels. They also assume that `post_pct` holds still around the start cycle, because the split is sampled only there. The bench drives every input on the falling edge and changes `post_pct` only while the block is idle. It holds the button for several cycles so that the synchronizer sees clean edges. The percentage sweep keeps extra `trig_in` pulses strictly inside the post-trigger window, so that each pulse the bench expects falls in the triggered state.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_TRIG  = 2'd2
    } phase_t;
endpackage

// File: rtl/cap_btn_sync.sv
// Button conditioner: synchronizer chain followed by a rising-edge detector.
module cap_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic btn_rise
);
    logic [STAGES-1:0] tap_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            tap_q  <= {tap_q[STAGES-2:0], btn_raw};
            prev_q <= tap_q[STAGES-1];
        end
    end

    assign btn_rise = tap_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cap_split.sv
// Splits the ring into post-trigger and pre-trigger shares from a percentage.
module cap_split #(
    parameter int ADDR_W = 6,
    parameter int PCT_W  = 7
) (
    input  logic [PCT_W-1:0]  pct,
    output logic [ADDR_W-1:0] post_n,
    output logic [ADDR_W-1:0] pre_n
);
    localparam int PW = ADDR_W + PCT_W + 1;
    localparam logic [PW-1:0]    HUNDRED = PW'(100);
    localparam logic [PCT_W-1:0] PMAX    = PCT_W'(99);
    localparam logic [ADDR_W:0]  DEPTH_V = (ADDR_W+1)'(1) << ADDR_W;

    logic [PCT_W-1:0]  p_clamped;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     quot;
    logic [ADDR_W:0]   pre_w;

    always_comb begin
        if (pct == '0)       p_clamped = PCT_W'(1);
        else if (pct > PMAX) p_clamped = PMAX;
        else                 p_clamped = pct;
        prod   = PW'(p_clamped) << ADDR_W;
        quot   = prod / HUNDRED;
        post_n = (quot == '0) ? ADDR_W'(1) : quot[ADDR_W-1:0];
        pre_w  = DEPTH_V - {1'b0, post_n};
        pre_n  = pre_w[ADDR_W-1:0];
    end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PCT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              trig_in,
    input  logic              btn_in,
    input  logic              sample_vld,
    input  logic [PCT_W-1:0]  post_pct,
    input  logic              pulse_every,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              st_idle,
    output logic              st_armed,
    output logic              st_trig,
    output logic              trig_pulse,
    output logic              done,
    output logic [ADDR_W-1:0] trig_addr,
    output logic              wrapped
);
    typedef struct packed {
        phase_t            ph;
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] pre_fill;
        logic [ADDR_W-1:0] pre_lim;
        logic [ADDR_W-1:0] post_cnt;
        logic [ADDR_W-1:0] post_tgt;
        logic [ADDR_W-1:0] tr_addr;
        logic              ovr;
        logic [ADDR_W-1:0] rec_addr;
        logic              rec_ovr;
        logic              done;
        logic              tpulse;
    } cap_state_t;

    cap_state_t        st_q, st_d;
    logic              btn_rise;
    logic [ADDR_W-1:0] split_post, split_pre;
    logic              wr_go;
    logic [ADDR_W-1:0] cnt_inc;

    cap_btn_sync #(.STAGES(2)) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (btn_in),
        .btn_rise(btn_rise)
    );

    cap_split #(.ADDR_W(ADDR_W), .PCT_W(PCT_W)) u_split (
        .pct   (post_pct),
        .post_n(split_post),
        .pre_n (split_pre)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.tpulse = 1'b0;
        wr_go       = sample_vld && (st_q.ph != PH_IDLE);
        cnt_inc     = st_q.post_cnt + 1'b1;
        if (wr_go) st_d.wptr = st_q.wptr + 1'b1;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_req || btn_rise) begin
                    st_d.ph       = PH_ARMED;
                    st_d.wptr     = '0;
                    st_d.pre_fill = '0;
                    st_d.post_cnt = '0;
                    st_d.ovr      = 1'b0;
                    st_d.post_tgt = split_post;
                    st_d.pre_lim  = split_pre;
                end
            end
            PH_ARMED: begin
                if (trig_in || btn_rise) begin
                    st_d.tpulse   = 1'b1;
                    st_d.tr_addr  = st_q.wptr;
                    st_d.post_cnt = sample_vld ? ADDR_W'(1) : '0;
                    if (sample_vld && st_q.post_tgt == ADDR_W'(1)) begin
                        st_d.ph       = PH_IDLE;
                        st_d.done     = 1'b1;
                        st_d.rec_addr = st_q.wptr;
                        st_d.rec_ovr  = st_q.ovr;
                    end else begin
                        st_d.ph = PH_TRIG;
                    end
                end else if (sample_vld) begin
                    if (st_q.pre_fill == st_q.pre_lim) st_d.ovr = 1'b1;
                    else                               st_d.pre_fill = st_q.pre_fill + 1'b1;
                end
            end
            PH_TRIG: begin
                if (trig_in && pulse_every) st_d.tpulse = 1'b1;
                if (btn_rise || (sample_vld && cnt_inc == st_q.post_tgt)) begin
                    st_d.ph       = PH_IDLE;
                    st_d.done     = 1'b1;
                    st_d.rec_addr = st_q.tr_addr;
                    st_d.rec_ovr  = st_q.ovr;
                end else if (sample_vld) begin
                    st_d.post_cnt = cnt_inc;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en      = wr_go;
    assign wr_addr    = st_q.wptr;
    assign st_idle    = (st_q.ph == PH_IDLE);
    assign st_armed   = (st_q.ph == PH_ARMED);
    assign st_trig    = (st_q.ph == PH_TRIG);
    assign trig_pulse = st_q.tpulse;
    assign done       = st_q.done;
    assign trig_addr  = st_q.rec_addr;
    assign wrapped    = st_q.rec_ovr;
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              st_idle,
    input logic              st_armed,
    input logic              st_trig,
    input logic              trig_pulse,
    input logic              done,
    input logic [ADDR_W-1:0] trig_addr,
    input logic              wrapped
);
    assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_idle, st_armed, st_trig}) == 1);

    assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !wr_en);

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_idle || wr_addr == $past(wr_addr) + 1'b1));

    assert_arm_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_armed) |-> $past(st_idle));

    assert_trig_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_trig |=> (st_trig || st_idle));

    assert_first_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_trig) |-> trig_pulse);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> st_idle);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_record_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(trig_addr) && $stable(wrapped)) |-> done);
endmodule

bind cap_ctrl cap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .st_idle   (st_idle),
    .st_armed  (st_armed),
    .st_trig   (st_trig),
    .trig_pulse(trig_pulse),
    .done      (done),
    .trig_addr (trig_addr),
    .wrapped   (wrapped)
);

// File: tb/cap_ctrl_test.sv
module cap_ctrl_test;
    localparam int CLK_T  = 10;
    localparam int ADDR_W = 4;
    localparam int PCT_W  = 7;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, trig_in = 1'b0, btn_in = 1'b0, sample_vld = 1'b0;
    logic [PCT_W-1:0] post_pct = 7'd50;
    logic pulse_every = 1'b0;
    logic wr_en, st_idle, st_armed, st_trig, trig_pulse, done, wrapped;
    logic [ADDR_W-1:0] wr_addr, trig_addr;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_done = 0, n_tp = 0, addr_err = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always #(CLK_T/2) clk = ~clk;

    cap_ctrl #(.ADDR_W(ADDR_W), .PCT_W(PCT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .trig_in(trig_in),
        .btn_in(btn_in), .sample_vld(sample_vld), .post_pct(post_pct),
        .pulse_every(pulse_every), .wr_en(wr_en), .wr_addr(wr_addr),
        .st_idle(st_idle), .st_armed(st_armed), .st_trig(st_trig),
        .trig_pulse(trig_pulse), .done(done), .trig_addr(trig_addr),
        .wrapped(wrapped)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one cycle: observe registered outputs, drive inputs, observe the write
    task automatic step(input logic v, input logic t, input logic s);
        @(negedge clk);
        if (done) n_done++;
        if (trig_pulse) n_tp++;
        sample_vld = v;
        trig_in    = t;
        start_req  = s;
        #1;
        if (wr_en) begin
            n_wr++;
            if (wr_addr != exp_addr) addr_err++;
            exp_addr = exp_addr + 1'b1;
        end
    endtask

    task automatic press();
        btn_in = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0);
        btn_in = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic clr();
        n_wr = 0; n_done = 0; n_tp = 0; addr_err = 0; exp_addr = '0;
    endtask

    initial begin
        #(CLK_T * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0);
        // R1: reset state
        chk(st_idle && !st_armed && !st_trig && !done && !trig_pulse && !wrapped
            && trig_addr == '0 && !wr_en, "R1", int'(st_idle), 1);
        step(1'b0, 1'b0, 1'b0);

        // ---- button walk-through, 50% of 16 -> post 8 ----
        post_pct = 7'd50; pulse_every = 1'b0;
        clr();
        press();
        chk(st_armed && !st_trig, "R11 long press makes one transition", int'(st_armed), 1);
        chk(st_armed, "R2 button start", int'(st_armed), 1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);          // R12: start_req while armed
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(st_armed && addr_err == 0 && n_wr == 5, "R12 start_req while armed ignored",
            n_wr, 5);
        press();
        chk(st_trig, "R3 button soft trigger", int'(st_trig), 1);
        chk(n_tp == 1, "R3 trigger pulse on soft trigger", n_tp, 1);
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0);
        press();
        chk(st_idle && n_done == 1, "R4 button stop", n_done, 1);
        chk(trig_addr == ADDR_W'(5) && !wrapped, "R4 record after stop", int'(trig_addr), 5);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(n_wr == 7, "R4 no writes after stop", n_wr, 7);
        step(1'b0, 1'b1, 1'b0);          // R12: trigger while idle
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(st_idle && n_tp == 1 && trig_addr == ADDR_W'(5), "R12 trig_in in idle ignored",
            n_tp, 1);

        // ---- percentage sweep, including out-of-range values ----
        for (int pct = 0; pct <= 101; pct++) begin
            int p, post, pre_lim, n_pre, extra;
            bit every;
            p = (pct < 1) ? 1 : ((pct > 99) ? 99 : pct);
            post = (DEPTH * p) / 100;
            if (post == 0) post = 1;
            pre_lim = DEPTH - post;
            n_pre = (pct * 7) % (2 * DEPTH + 1);
            every = pct[0];
            post_pct = PCT_W'(pct);
            pulse_every = every;
            clr();
            step(1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0);
            if (pct % 17 == 0)
                chk(st_armed, "R2 start_req arms", int'(st_armed), 1);
            for (int i = 0; i < n_pre; i++) step(1'b1, 1'b0, 1'b0);
            extra = 0;
            for (int j = 0; j < post + 2; j++) begin
                bit t;
                t = (j == 0) || (j < post && j % 3 == 1);
                if (j > 0 && t && every) extra++;
                step(1'b1, t, 1'b0);
            end
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            chk(n_wr == n_pre + post, "R5 post-trigger sample count", n_wr - n_pre, post);
            chk(n_done == 1 && st_idle, "R10 single done pulse", n_done, 1);
            chk(int'(trig_addr) == n_pre % DEPTH, "R10 trigger address",
                int'(trig_addr), n_pre % DEPTH);
            if (n_pre > pre_lim)
                chk(wrapped == 1'b1, "R7 overrun flag", int'(wrapped), 1);
            else
                chk(wrapped == 1'b0, "R6 early trigger leaves region unused", int'(wrapped), 0);
            chk(n_tp == 1 + extra, every ? "R9 pulse on every trigger" : "R8 later triggers ignored",
                n_tp, 1 + extra);
            chk(addr_err == 0, "R2 ring address sequence", addr_err, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule